// File: doc/BRIEF.md
# Load-Switch Serial Command and Status Port

This block is the serial slave port of a four-channel load-switch controller. It runs entirely on the system clock. It oversamples the serial clock, data and select pins through synchronizers and finds their edges in the system clock domain. Each select frame carries one 16-bit command word. The top bit is the watchdog toggle, the next three bits address a configuration register, and the low twelve bits are the register data.

The frame is only acted on if exactly sixteen clocks arrived before select returns high. In that case the data is written to the addressed register, and the toggle bit is kept for the watchdog logic.

In the same frame the port shifts out a status word. That word is taken when select goes low, and it holds the latched fault flags, the channel input states and the current toggle value. Fault flags that a complete frame has reported are cleared when that frame ends. Faults that arrive while the frame is in progress remain latched for the next read.

Top module: `lsw_spi_regif`

## Requirements
- R1: After reset every configuration register reads zero, the watchdog toggle output is 0, no fault is latched and the serial output enable is 0.
- R2: The serial output enable is 1 only while the select pin is low; it returns to 0 after select goes high.
- R3: A 16-clock frame writes data bits D11..D0 into the register whose index is given by D14..D12 when select rises, and leaves every other register unchanged.
- R4: Incoming bits are taken on falling serial-clock edges, most significant bit (D15) first.
- R5: A frame with 15 or 17 serial clocks updates no register and does not change the watchdog toggle.
- R6: Bit D15 of every 16-clock frame is copied to the watchdog toggle output, including frames whose address is at or above the register count (6 by default). Such frames write no register.
- R7: The status word is, most significant bit first: bits 15..8 the latched faults (fault input bit k at status bit 8+k), bits 7..4 the channel inputs (input k at bit 4+k), bit 3 the watchdog toggle, bits 2..0 zero. The word changes on rising serial-clock edges, and the first rising edge presents bit 15.
- R8: A one-cycle pulse on a fault input bit latches that fault. It stays latched until a read reports it.
- R9: Faults reported by a 16-clock frame are cleared when that frame ends. A fault pulsed during the frame stays latched and appears in the next read.
- R10: A frame that does not have exactly 16 clocks clears no fault.
- R11: While select is high, serial clock and data activity has no effect: no register changes, the output stays disabled, and the next frame is received and transmitted normally.
- R12: The status word is captured when select falls. Channel input changes later in the frame do not alter the word being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Active-low select pin |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out; 0 when disabled |
| spi_so_oe | output | 1 | Output enable for the serial data pin (1 = drive, 0 = high impedance) |
| flt_set_i | input | 8 | Fault event pulses, two per channel |
| chan_in_i | input | 4 | Channel input pin states |
| cfg_o | output | 72 | Configuration registers, register r at bits r*12 +: 12 |
| wd_toggle_o | output | 1 | Watchdog toggle bit from the last valid frame |

## Verification
Commands are driven with data patterns that have only the top data bit set, only the bottom data bit set, and mixed bits. A swapped or shifted bit order therefore shows up as a wrong register value. Frames of 15 and 17 clocks sit on both sides of the valid length, and unused addresses are also sent. Together these separate length gating and address decode from a correct write. Faults are pulsed between frames, before short frames and in the middle of frames. This distinguishes clearing only what was reported from clearing everything or nothing. A change of the channel inputs in mid-frame shows whether the status is captured or read live. Clock toggling while the port is deselected tests whether the edge detectors are gated by select.

// File: rtl/lsw_spi_pkg.sv
// Shared constants and types for the load-switch serial port.
// Assumes a 16-bit word with the watchdog toggle in the top bit.
package lsw_spi_pkg;
    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = WORD_W - 1 - ADDR_W;
    localparam int NUM_CH     = 4;
    localparam int FLT_PER_CH = 2;
    localparam int FLT_W      = NUM_CH * FLT_PER_CH;
    localparam int NUM_REGS   = 6;
    localparam int CNT_W      = $clog2(WORD_W + 2);
    localparam int PAD_W      = WORD_W - FLT_W - NUM_CH - 1;

    // Command word layout (bit order is behaviour: decode depends on it)
    typedef struct packed {
        logic              wd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    // Assemble the outgoing status word
    function automatic logic [WORD_W-1:0] pack_status(
        input logic [FLT_W-1:0]  flt,
        input logic [NUM_CH-1:0] ins,
        input logic              wd
    );
        return {flt, ins, wd, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/lsw_spi_sync.sv
// Pin synchronizer and edge finder.
// Brings SCLK, SI and CS_N through SYNC_STAGES flops and derives single-cycle
// edge strobes in the system clock domain. Clock edges are reported only
// while select is low. Assumes the system clock is at least 4x the serial clock.
module lsw_spi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic si_i,
    input  logic cs_n_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic si_s,
    output logic cs_low,
    output logic cs_fall,
    output logic cs_rise
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE = 3'b100; // cs_n high, si low, sclk low

    logic [SYNC_STAGES-1:0][NPIN-1:0] stage_q;
    logic [NPIN-1:0] pin_s;
    logic            sclk_d, cs_n_d;

    // Shift the raw pins through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= IDLE;
        end else begin
            stage_q[0] <= {cs_n_i, si_i, sclk_i};
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_s = stage_q[SYNC_STAGES-1];

    // Remember the previous synchronized clock and select levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_n_d <= 1'b1;
        end else begin
            sclk_d <= pin_s[0];
            cs_n_d <= pin_s[2];
        end
    end

    assign si_s      = pin_s[1];
    assign cs_low    = !pin_s[2];
    assign cs_fall   = !pin_s[2] && cs_n_d;
    assign cs_rise   = pin_s[2] && !cs_n_d;
    assign sclk_rise = cs_low && !cs_fall && pin_s[0] && !sclk_d;
    assign sclk_fall = cs_low && !cs_fall && !pin_s[0] && sclk_d;
endmodule

// File: rtl/lsw_spi_shifter.sv
// Frame shifter: receives the command word on falling clock edges and
// sends the status word on rising clock edges, MSB first. It counts clocks,
// saturating above the word length, and flags a valid frame when select rises
// after exactly WORD_W clocks.
module lsw_spi_shifter
    import lsw_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              si_s,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic [WORD_W-1:0] status_i,
    output logic [WORD_W-1:0] rx_word,
    output logic              frame_ok,
    output logic              so,
    output logic              so_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic [CNT_W-1:0]  cnt;
    logic              so_q;

    // Load status at select fall; shift out on rise and shift in on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
            cnt   <= '0;
            so_q  <= 1'b0;
        end else if (cs_fall) begin
            tx_sh <= status_i;
            rx_sh <= '0;
            cnt   <= '0;
            so_q  <= 1'b0;
        end else begin
            if (sclk_rise) begin
                so_q  <= tx_sh[WORD_W-1];
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
            if (sclk_fall) begin
                rx_sh <= {rx_sh[WORD_W-2:0], si_s};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
        end
    end

    assign rx_word  = rx_sh;
    assign frame_ok = cs_rise && (cnt == CNT_FULL);
    assign so       = cs_low ? so_q : 1'b0;
    assign so_oe    = cs_low;
endmodule

// File: rtl/lsw_spi_regbank.sv
// Configuration register bank: commits a valid frame's data to the addressed
// register and keeps the watchdog toggle bit. Addresses at or above
// NUM_REGS match no register. Every register resets to zero.
module lsw_spi_regbank
    import lsw_spi_pkg::*;
#(
    parameter int NUM_REGS = lsw_spi_pkg::NUM_REGS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_ok,
    input  logic [WORD_W-1:0]          rx_word,
    output logic [NUM_REGS*DATA_W-1:0] cfg_o,
    output logic                       wd_toggle_o
);
    cmd_t cmd;
    assign cmd = cmd_t'(rx_word);

    logic wd_q;

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [DATA_W-1:0] val_q;
            // Write this register when a valid frame addresses it
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (frame_ok && (cmd.addr == ADDR_W'(r)))
                    val_q <= cmd.data;
            end
            assign cfg_o[r*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

    // Keep the toggle bit of every valid frame
    always_ff @(posedge clk) begin
        if (!rst_n)        wd_q <= 1'b0;
        else if (frame_ok) wd_q <= cmd.wd;
    end

    assign wd_toggle_o = wd_q;
endmodule

// File: rtl/lsw_spi_status.sv
// Fault latch and status assembly. Fault pulses set sticky flags. The flags
// present at select fall are remembered, and at the end of a valid frame only
// those are cleared, minus any that were pulsed again during the frame.
module lsw_spi_status
    import lsw_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLT_W-1:0]  flt_set_i,
    input  logic [NUM_CH-1:0] chan_in_i,
    input  logic              wd_i,
    input  logic              cs_fall,
    input  logic              frame_ok,
    output logic [FLT_W-1:0]  flt_lat_o,
    output logic [WORD_W-1:0] status_o
);
    logic [FLT_W-1:0] lat_q, cap_q, fresh_q, clr;

    // Bits to drop: reported at select fall and not pulsed since
    assign clr = frame_ok ? (cap_q & ~(fresh_q | flt_set_i)) : '0;

    // Latch faults, remember reported set, track faults new in this frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q   <= '0;
            cap_q   <= '0;
            fresh_q <= '0;
        end else begin
            lat_q <= (lat_q & ~clr) | flt_set_i;
            if (cs_fall) begin
                cap_q   <= lat_q;
                fresh_q <= flt_set_i;
            end else begin
                fresh_q <= fresh_q | flt_set_i;
            end
        end
    end

    assign flt_lat_o = lat_q;
    assign status_o  = pack_status(lat_q, chan_in_i, wd_i);
endmodule

// File: rtl/lsw_spi_regif.sv
// Top of the load-switch serial port: synchronizer, frame shifter,
// register bank and fault/status logic. All logic is in the clk domain;
// the serial pins are asynchronous to it.
module lsw_spi_regif
    import lsw_spi_pkg::*;
#(
    parameter int NUM_REGS    = lsw_spi_pkg::NUM_REGS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_si,
    output logic                       spi_so,
    output logic                       spi_so_oe,
    input  logic [FLT_W-1:0]           flt_set_i,
    input  logic [NUM_CH-1:0]          chan_in_i,
    output logic [NUM_REGS*DATA_W-1:0] cfg_o,
    output logic                       wd_toggle_o
);
    logic sclk_rise, sclk_fall, si_s, cs_low, cs_fall, cs_rise;
    logic frame_ok;
    logic [WORD_W-1:0] rx_word, status_w;
    logic [FLT_W-1:0]  flt_lat;

    lsw_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(spi_sclk), .si_i(spi_si), .cs_n_i(spi_cs_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si_s(si_s),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    lsw_spi_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si_s(si_s),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .status_i(status_w), .rx_word(rx_word), .frame_ok(frame_ok),
        .so(spi_so), .so_oe(spi_so_oe)
    );

    lsw_spi_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .frame_ok(frame_ok), .rx_word(rx_word),
        .cfg_o(cfg_o), .wd_toggle_o(wd_toggle_o)
    );

    lsw_spi_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .flt_set_i(flt_set_i), .chan_in_i(chan_in_i), .wd_i(wd_toggle_o),
        .cs_fall(cs_fall), .frame_ok(frame_ok),
        .flt_lat_o(flt_lat), .status_o(status_w)
    );
endmodule

// File: rtl/lsw_spi_regif_chk.sv
// Property checker for lsw_spi_regif, attached with bind below.
module lsw_spi_regif_chk
    import lsw_spi_pkg::*;
#(
    parameter int NUM_REGS = lsw_spi_pkg::NUM_REGS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       spi_cs_n,
    input logic                       spi_so_oe,
    input logic                       frame_ok,
    input logic [WORD_W-1:0]          rx_word,
    input logic [NUM_REGS*DATA_W-1:0] cfg_o,
    input logic                       wd_toggle_o,
    input logic [FLT_W-1:0]           flt_set_i,
    input logic [FLT_W-1:0]           flt_lat
);
    // R2: a long-deselected port never drives its output
    assert_so_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_so_oe);

    // R3, R5: configuration only moves after a valid frame
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(cfg_o));

    // R6: the toggle output follows the top bit of each valid frame
    assert_wd_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> (wd_toggle_o == $past(rx_word[WORD_W-1])));

    // R8: a pulsed fault is latched on the next cycle
    assert_fault_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_set_i) |=> ((flt_lat & $past(flt_set_i)) == $past(flt_set_i)));

    // R10: faults drop only at the end of a valid frame
    assert_fault_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> ((~flt_lat & $past(flt_lat)) == '0));
endmodule

bind lsw_spi_regif lsw_spi_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
    .frame_ok(frame_ok), .rx_word(rx_word), .cfg_o(cfg_o),
    .wd_toggle_o(wd_toggle_o), .flt_set_i(flt_set_i), .flt_lat(flt_lat)
);

// File: tb/lsw_spi_regif_bench.sv
// Scoreboard bench: the frame driver queues the expected status word, and a
// monitor rebuilds the word from the output pin and compares it.
module lsw_spi_regif_bench;
    localparam int NR = 6;
    localparam int DW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, si = 1'b0, cs_n = 1'b1;
    logic so, so_oe, wd;
    logic [7:0] flt_set = '0;
    logic [3:0] chan_in = 4'b1010;
    logic [NR*DW-1:0] cfg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] exp_cfg [NR];
    logic [7:0]    exp_flt = '0;
    logic          exp_wd  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    lsw_spi_regif u_lsw_spi_regif (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_si(si), .spi_so(so), .spi_so_oe(so_oe), .flt_set_i(flt_set),
        .chan_in_i(chan_in), .cfg_o(cfg), .wd_toggle_o(wd)
    );

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < NR; r++)
            check_eq(tag, $sformatf("cfg[%0d]", r), 32'(cfg[r*DW +: DW]), 32'(exp_cfg[r]));
        check_eq(tag, "wd_toggle", 32'(wd), 32'(exp_wd));
    endtask

    // Driver: one frame of n clocks; optional mid-frame fault and input flips
    task automatic spi_frame(input logic [15:0] w, input int n,
                             input logic [7:0] mid_flt, input logic [3:0] mid_in,
                             input string tag);
        logic [7:0] cap;
        cap = exp_flt;
        if (n == 16) begin
            exp_q.push_back({exp_flt, chan_in, exp_wd, 3'b000});
            tag_q.push_back(tag);
        end
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            si   = (i < 16) ? w[15-i] : 1'b0;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            repeat (8) @(negedge clk);
            if (i == 0) check_eq("R2", "so_oe in frame", 32'(so_oe), 32'd1);
            if (i == 8) begin
                if (mid_flt != '0) begin
                    flt_set = mid_flt;
                    @(negedge clk) flt_set = '0;
                end
                chan_in = chan_in ^ mid_in;
            end
        end
        cs_n = 1'b1;
        si   = 1'b0;
        repeat (12) @(negedge clk);
        check_eq("R2", "so_oe after frame", 32'(so_oe), 32'd0);
        if (n == 16) begin
            exp_flt = (exp_flt & ~cap) | mid_flt;
            exp_wd  = w[15];
            if (int'(w[14:12]) < NR) exp_cfg[w[14:12]] = w[11:0];
        end else begin
            exp_flt = exp_flt | mid_flt;
        end
    endtask

    task automatic pulse_fault(input logic [7:0] m);
        @(negedge clk) flt_set = m;
        @(negedge clk) flt_set = '0;
        exp_flt = exp_flt | m;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: master-side sampling of the output on falling clock edges
    int          nb = 0;
    logic [15:0] got = '0;
    always @(negedge cs_n) begin
        nb  = 0;
        got = '0;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            if (nb < 16) got[15-nb] = so;
            nb++;
        end
    end
    always @(posedge cs_n) begin
        if (nb == 16 && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (got !== e) begin
                fails++;
                $display("FAIL %s status word: actual %h expected %h", t, got, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) exp_cfg[r] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check_regs("R1");
        check_eq("R1", "so_oe", 32'(so_oe), 32'd0);

        // R3 R4: writes with mixed, top-only and bottom-only data
        spi_frame({1'b0, 3'd0, 12'hA5C}, 16, 8'h00, 4'h0, "R3");
        check_regs("R3");
        spi_frame({1'b1, 3'd5, 12'h3F1}, 16, 8'h00, 4'h0, "R6");
        check_regs("R6");
        spi_frame({1'b0, 3'd1, 12'h001}, 16, 8'h00, 4'h0, "R4");
        spi_frame({1'b1, 3'd2, 12'h800}, 16, 8'h00, 4'h0, "R4");
        check_regs("R4");

        // R5: wrong lengths on both sides
        spi_frame({1'b0, 3'd3, 12'hFFF}, 15, 8'h00, 4'h0, "R5");
        check_regs("R5");
        spi_frame({1'b0, 3'd3, 12'hFFF}, 17, 8'h00, 4'h0, "R5");
        check_regs("R5");

        // R6: addresses beyond the bank still carry the toggle
        spi_frame({1'b0, 3'd7, 12'hFFF}, 16, 8'h00, 4'h0, "R6");
        check_regs("R6");
        spi_frame({1'b1, 3'd6, 12'hABC}, 16, 8'h00, 4'h0, "R6");
        check_regs("R6");

        // R7 R8: faults appear in the status word; R9: cleared after read
        pulse_fault(8'h81);
        spi_frame({1'b0, 3'd4, 12'h111}, 16, 8'h00, 4'h0, "R7 R8");
        spi_frame({1'b0, 3'd4, 12'h222}, 16, 8'h00, 4'h0, "R9");
        check_regs("R9");

        // R10: short frame keeps faults; R12: mid-frame input change not seen
        pulse_fault(8'h10);
        spi_frame({1'b0, 3'd4, 12'hEEE}, 15, 8'h00, 4'h0, "R10");
        spi_frame({1'b0, 3'd3, 12'h0F0}, 16, 8'h04, 4'b0110, "R12");
        spi_frame({1'b1, 3'd3, 12'h707}, 16, 8'h00, 4'h0, "R9");
        check_regs("R9");

        // R11: clock and data activity while deselected
        @(negedge clk) si = 1'b1;
        for (int k = 0; k < 20; k++) begin
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            if (k == 10) check_eq("R11", "so_oe deselected", 32'(so_oe), 32'd0);
        end
        si = 1'b0;
        repeat (6) @(negedge clk);
        check_regs("R11");
        spi_frame({1'b0, 3'd2, 12'h5A5}, 16, 8'h00, 4'h0, "R11");
        check_regs("R11");

        repeat (10) @(negedge clk);
        check_eq("R7", "scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule